// File: doc/BRIEF.md
# Indexed Display-Identification Mailbox

This block is a device-side register bank. A host uses it to read a display identification table four bytes at a time through a port of 8-bit indexed registers. The host selects a register by index. It either writes a value under a bit mask or reads the selected register back on a combinational data output. The table lives in an internal 256-byte store. A side write port loads that store, one byte per cycle.

To fetch a word, the host writes a pointer in units of four bytes. A fetch state machine then waits a programmable latency. It copies the four addressed bytes into snapshot data registers, echoes the pointer into a read-only mirror register and raises a valid flag. The host treats the data as usable only when the mirror equals the pointer it wrote and the valid flag is set.

The whole exchange is gated by three status inputs: firmware running, link up and hot-plug present. If any of them is low, the valid flag is held low. The host also owns a done flag, which it clears before a table read and sets when the read ends or is abandoned.

The fetch machine has three states:
- `FS_IDLE`: nothing pending, valid low.
- `FS_FETCH`: latency countdown running.
- `FS_HOLD`: snapshot held, valid high.

Its transitions are:
- `pointer write`: any state to `FS_FETCH`.
- `countdown done, pointer legal, status good`: `FS_FETCH` to `FS_HOLD`.
- `countdown done, pointer illegal`: `FS_FETCH` to `FS_IDLE`.
- `status lost`: `FS_FETCH` or `FS_HOLD` to `FS_IDLE`.

Top module: `edid_mbox`

## Requirements
- R1: After reset, the following registers read zero: pointer (0x18), mirror (0x19), valid (0x1A), the four data registers (0x1C to 0x1F) and control (0x20). The latency register (0x21) reads 4.
- R2: The status registers read live inputs. Index 0x10 returns firmware-running at bit 5. Index 0x11 returns link-up at bit 0. Index 0x12 returns hot-plug at bit 0. All other bits of these registers read 0.
- R3: A host write to a writable register (pointer 0x18, control 0x20, latency 0x21) changes only the bits set in the write mask. The new value is (old & ~mask) | (wdata & mask).
- R4: A write to the pointer register clears the valid flag (0x1A bit 0) at the same clock edge.
- R5: With all status inputs high, the valid flag rises and the mirror takes the pointer value exactly L clock edges after the pointer write edge. L is the latency register value, and a value of 0 behaves as 1.
- R6: While valid, data registers 0x1C, 0x1D, 0x1E and 0x1F hold store bytes 4P, 4P+1, 4P+2 and 4P+3 for pointer P, taken when valid rose. Bytes beyond address 255 read 0, so pointer 64 gives all zeros.
- R7: A pointer above 64 never sets the valid flag and leaves the mirror unchanged.
- R8: Valid is never high unless all three status inputs were high at the previous edge. A status bit that clears during a fetch or while valid leaves the flag low until the next pointer write.
- R9: Host writes to read-only indices (status, mirror, valid, data) have no effect. Unmapped indices read 0.
- R10: A side-port write places its byte in the store, and a later fetch returns that byte.
- R11: The host-done flag is bit 0 of control register 0x20. It is freely readable and writable and has no effect on the fetch state or the valid flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the selected index |
| host_idx | input | 8 | Register index for read and write |
| host_wdata | input | 8 | Host write data |
| host_wmask | input | 8 | Bit mask selecting which bits a write changes |
| host_rdata | output | 8 | Combinational readback of the selected index |
| fw_running | input | 1 | Firmware running status |
| link_up | input | 1 | Link trained status |
| hpd_present | input | 1 | Hot-plug present status |
| tbl_we | input | 1 | Side-port store write enable |
| tbl_addr | input | 8 | Side-port store byte address |
| tbl_wdata | input | 8 | Side-port store byte |

## Verification
The assertions assume that the status inputs and the host strobe are synchronous to the clock and change only between edges. They also assume that `host_idx` is stable whenever `host_wr` is high. The bench respects this by driving every input on the falling edge and sampling `host_rdata` one time step later. Status loss is forced only from those falling-edge drives, both during a countdown and while the snapshot is held. The checks therefore see the flag drop at a known edge rather than at an ambiguous one.

// File: rtl/edid_mbox_pkg.sv
package edid_mbox_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FETCH = 2'd1,
        FS_HOLD  = 2'd2
    } fetch_state_t;

    localparam logic [7:0] IDX_STAT_FW   = 8'h10;
    localparam logic [7:0] IDX_STAT_LINK = 8'h11;
    localparam logic [7:0] IDX_STAT_HPD  = 8'h12;
    localparam logic [7:0] IDX_PTR       = 8'h18;
    localparam logic [7:0] IDX_MIRROR    = 8'h19;
    localparam logic [7:0] IDX_VALID     = 8'h1A;
    localparam logic [7:0] IDX_DATA0     = 8'h1C;
    localparam logic [7:0] IDX_DATA1     = 8'h1D;
    localparam logic [7:0] IDX_DATA2     = 8'h1E;
    localparam logic [7:0] IDX_DATA3     = 8'h1F;
    localparam logic [7:0] IDX_CTRL      = 8'h20;
    localparam logic [7:0] IDX_LAT       = 8'h21;

    localparam int LANES  = 4;
    localparam int FW_BIT = 5;

endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [7:0]             wdata,
    input  logic [7:0]             ptr,
    output logic [3:0][7:0]        lanes
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BA_W  = (ADDR_W > 10) ? ADDR_W + 1 : 11;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [BA_W-1:0] ba;
        logic            in_range;

        always_comb begin
            ba       = BA_W'({ptr, 2'b00}) + BA_W'(g);
            in_range = (ba < BA_W'(DEPTH));
            lanes[g] = in_range ? mem[ba[ADDR_W-1:0]] : 8'h00;
        end
    end

endmodule

// File: rtl/mbox_fetch.sv
module mbox_fetch
    import edid_mbox_pkg::*;
#(
    parameter int PTR_MAX = 64,
    parameter int LAT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [7:0]        ptr_val,
    input  logic [LAT_W-1:0]  lat,
    input  logic              stat_ok,
    input  logic [3:0][7:0]   lanes,
    output logic              valid,
    output logic [7:0]        mirror,
    output logic [3:0][7:0]   snap
);
    localparam logic [7:0] PTR_LIM = PTR_MAX[7:0];

    fetch_state_t     st, st_n;
    logic [LAT_W-1:0] cnt, cnt_n;
    logic             cap;
    logic [7:0]       mirror_q;
    logic [3:0][7:0]  snap_q;

    // next-state logic
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        cap   = 1'b0;
        unique case (st)
            FS_IDLE: begin
            end
            FS_FETCH: begin
                if (!stat_ok) begin
                    st_n = FS_IDLE;
                end else if (cnt == '0) begin
                    if (ptr_val <= PTR_LIM) begin
                        st_n = FS_HOLD;
                        cap  = 1'b1;
                    end else begin
                        st_n = FS_IDLE;
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            FS_HOLD: begin
                if (!stat_ok) begin
                    st_n = FS_IDLE;
                end
            end
            default: st_n = FS_IDLE;
        endcase
        if (ptr_wr) begin
            st_n  = FS_FETCH;
            cnt_n = (lat == '0) ? '0 : lat - 1'b1;
            cap   = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FS_IDLE;
            cnt      <= '0;
            mirror_q <= '0;
            snap_q   <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (cap) begin
                mirror_q <= ptr_val;
                snap_q   <= lanes;
            end
        end
    end

    // outputs
    always_comb begin
        valid  = (st == FS_HOLD);
        mirror = mirror_q;
        snap   = snap_q;
    end

    assert_valid_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(stat_ok));

    assert_ptr_clears_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> !valid);

    assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (mirror <= PTR_LIM));

    assert_mirror_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (mirror == ptr_val));

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import edid_mbox_pkg::*;
#(
    parameter int LAT_W   = 8,
    parameter int LAT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [7:0]        host_idx,
    input  logic [7:0]        host_wdata,
    input  logic [7:0]        host_wmask,
    input  logic              fw_running,
    input  logic              link_up,
    input  logic              hpd_present,
    input  logic              valid,
    input  logic [7:0]        mirror,
    input  logic [3:0][7:0]   snap,
    output logic [7:0]        ptr_q,
    output logic              ptr_wr,
    output logic [LAT_W-1:0]  lat_q,
    output logic [7:0]        host_rdata
);
    logic [7:0] ctrl_q;
    logic [7:0] lat_full;
    logic       wr_ctrl, wr_lat;

    always_comb begin
        ptr_wr  = host_wr && (host_idx == IDX_PTR);
        wr_ctrl = host_wr && (host_idx == IDX_CTRL);
        wr_lat  = host_wr && (host_idx == IDX_LAT);
        lat_full = 8'(lat_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            ctrl_q <= '0;
            lat_q  <= LAT_W'(LAT_RST);
        end else begin
            if (ptr_wr) begin
                ptr_q <= (ptr_q & ~host_wmask) | (host_wdata & host_wmask);
            end
            if (wr_ctrl) begin
                ctrl_q <= (ctrl_q & ~host_wmask) | (host_wdata & host_wmask);
            end
            if (wr_lat) begin
                lat_q <= LAT_W'((lat_full & ~host_wmask) | (host_wdata & host_wmask));
            end
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        case (host_idx)
            IDX_STAT_FW:   host_rdata[FW_BIT] = fw_running;
            IDX_STAT_LINK: host_rdata[0] = link_up;
            IDX_STAT_HPD:  host_rdata[0] = hpd_present;
            IDX_PTR:       host_rdata = ptr_q;
            IDX_MIRROR:    host_rdata = mirror;
            IDX_VALID:     host_rdata[0] = valid;
            IDX_DATA0:     host_rdata = snap[0];
            IDX_DATA1:     host_rdata = snap[1];
            IDX_DATA2:     host_rdata = snap[2];
            IDX_DATA3:     host_rdata = snap[3];
            IDX_CTRL:      host_rdata = ctrl_q;
            IDX_LAT:       host_rdata = lat_full;
            default:       host_rdata = 8'h00;
        endcase
    end

    assert_ro_ptr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_idx != IDX_PTR) |=> $stable(ptr_q));

endmodule

// File: rtl/edid_mbox.sv
module edid_mbox #(
    parameter int ADDR_W  = 8,
    parameter int PTR_MAX = 64,
    parameter int LAT_W   = 8,
    parameter int LAT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [7:0]        host_idx,
    input  logic [7:0]        host_wdata,
    input  logic [7:0]        host_wmask,
    output logic [7:0]        host_rdata,
    input  logic              fw_running,
    input  logic              link_up,
    input  logic              hpd_present,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [7:0]        tbl_wdata
);
    logic [7:0]       ptr_q;
    logic             ptr_wr;
    logic [LAT_W-1:0] lat_q;
    logic             stat_ok;
    logic             valid;
    logic [7:0]       mirror;
    logic [3:0][7:0]  lanes;
    logic [3:0][7:0]  snap;

    assign stat_ok = fw_running & link_up & hpd_present;

    mbox_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .ptr   (ptr_q),
        .lanes (lanes)
    );

    mbox_fetch #(.PTR_MAX(PTR_MAX), .LAT_W(LAT_W)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_wr  (ptr_wr),
        .ptr_val (ptr_q),
        .lat     (lat_q),
        .stat_ok (stat_ok),
        .lanes   (lanes),
        .valid   (valid),
        .mirror  (mirror),
        .snap    (snap)
    );

    mbox_regs #(.LAT_W(LAT_W), .LAT_RST(LAT_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_idx    (host_idx),
        .host_wdata  (host_wdata),
        .host_wmask  (host_wmask),
        .fw_running  (fw_running),
        .link_up     (link_up),
        .hpd_present (hpd_present),
        .valid       (valid),
        .mirror      (mirror),
        .snap        (snap),
        .ptr_q       (ptr_q),
        .ptr_wr      (ptr_wr),
        .lat_q       (lat_q),
        .host_rdata  (host_rdata)
    );

endmodule

// File: tb/sim_edid_mbox.sv
module sim_edid_mbox;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_idx = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_wmask = 8'h00;
    logic [7:0] host_rdata;
    logic       fw_running = 1'b1;
    logic       link_up = 1'b1;
    logic       hpd_present = 1'b1;
    logic       tbl_we = 1'b0;
    logic [7:0] tbl_addr = 8'h00;
    logic [7:0] tbl_wdata = 8'h00;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    edid_mbox u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_wmask(host_wmask), .host_rdata(host_rdata),
        .fw_running(fw_running), .link_up(link_up), .hpd_present(hpd_present),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
    );

    function automatic logic [7:0] tbyte(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] idx, output logic [7:0] v);
        host_idx = idx;
        #1;
        v = host_rdata;
    endtask

    task automatic hw(logic [7:0] idx, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        host_wr = 1'b1; host_idx = idx; host_wdata = d; host_wmask = m;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // writes pointer, waits latency, leaves at negedge after valid should rise
    task automatic fetch(logic [7:0] p, int lat);
        hw(8'h18, p, 8'hFF);
        repeat (lat) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(8'h18, v); chk("R1 ptr", v, 8'h00);
        rd(8'h19, v); chk("R1 mirror", v, 8'h00);
        rd(8'h1A, v); chk("R1 valid", v, 8'h00);
        rd(8'h1C, v); chk("R1 data0", v, 8'h00);
        rd(8'h1F, v); chk("R1 data3", v, 8'h00);
        rd(8'h20, v); chk("R1 ctrl", v, 8'h00);
        rd(8'h21, v); chk("R1 lat", v, 8'h04);
    endtask

    task automatic t_status;
        logic [7:0] v;
        @(negedge clk);
        fw_running = 1'b1; link_up = 1'b0; hpd_present = 1'b1;
        rd(8'h10, v); chk("R2 fw", v, 8'h20);
        rd(8'h11, v); chk("R2 link", v, 8'h00);
        rd(8'h12, v); chk("R2 hpd", v, 8'h01);
        fw_running = 1'b0; link_up = 1'b1; hpd_present = 1'b0;
        rd(8'h10, v); chk("R2 fw off", v, 8'h00);
        rd(8'h11, v); chk("R2 link on", v, 8'h01);
        rd(8'h12, v); chk("R2 hpd off", v, 8'h00);
        fw_running = 1'b1; link_up = 1'b1; hpd_present = 1'b1;
    endtask

    task automatic t_mask;
        logic [7:0] v;
        hw(8'h21, 8'h0A, 8'hFF);
        rd(8'h21, v); chk("R3 lat full", v, 8'h0A);
        hw(8'h21, 8'h35, 8'h0F);
        rd(8'h21, v); chk("R3 lat masked", v, 8'h05);
        hw(8'h20, 8'hFF, 8'h00);
        rd(8'h20, v); chk("R3 ctrl mask zero", v, 8'h00);
    endtask

    task automatic t_fetch_timing;
        logic [7:0] v;
        hw(8'h21, 8'h05, 8'hFF);
        hw(8'h18, 8'h03, 8'hFF);
        repeat (4) @(negedge clk);
        rd(8'h1A, v); chk("R5 valid before L", v, 8'h00);
        @(negedge clk);
        rd(8'h1A, v); chk("R5 valid at L", v, 8'h01);
        rd(8'h19, v); chk("R5 mirror", v, 8'h03);
        for (int k = 0; k < 4; k++) begin
            rd(8'(8'h1C + k), v); chk("R6 data p3", v, tbyte(12 + k));
        end
    endtask

    task automatic t_rewrite;
        logic [7:0] v;
        hw(8'h18, 8'h1F, 8'hFF);
        rd(8'h1A, v); chk("R4 valid cleared", v, 8'h00);
        repeat (5) @(negedge clk);
        rd(8'h1A, v); chk("R5 valid p31", v, 8'h01);
        rd(8'h1C, v); chk("R6 data0 p31", v, tbyte(124));
        rd(8'h1F, v); chk("R6 data3 p31", v, tbyte(127));
    endtask

    task automatic t_lat_zero;
        logic [7:0] v;
        hw(8'h21, 8'h00, 8'hFF);
        hw(8'h18, 8'h01, 8'hFF);
        @(negedge clk);
        rd(8'h1A, v); chk("R5 lat0 as 1", v, 8'h01);
        rd(8'h1D, v); chk("R6 data1 p1", v, tbyte(5));
        hw(8'h21, 8'h03, 8'hFF);
    endtask

    task automatic t_ptr_edges;
        logic [7:0] v;
        fetch(8'h40, 3);
        rd(8'h1A, v); chk("R6 ptr64 valid", v, 8'h01);
        rd(8'h1C, v); chk("R6 ptr64 zero", v, 8'h00);
        rd(8'h1F, v); chk("R6 ptr64 zero3", v, 8'h00);
        fetch(8'h41, 3);
        repeat (20) @(negedge clk);
        rd(8'h1A, v); chk("R7 ptr65 not valid", v, 8'h00);
        rd(8'h19, v); chk("R7 mirror kept", v, 8'h40);
        fetch(8'hFF, 3);
        rd(8'h1A, v); chk("R7 ptr255 not valid", v, 8'h00);
    endtask

    task automatic t_status_loss;
        logic [7:0] v;
        fetch(8'h02, 3);
        rd(8'h1A, v); chk("R8 valid before drop", v, 8'h01);
        link_up = 1'b0;
        @(negedge clk);
        rd(8'h1A, v); chk("R8 valid drops on link", v, 8'h00);
        link_up = 1'b1;
        @(negedge clk);
        rd(8'h1A, v); chk("R8 stays low after restore", v, 8'h00);
        hw(8'h18, 8'h04, 8'hFF);
        hpd_present = 1'b0;
        @(negedge clk);
        hpd_present = 1'b1;
        repeat (6) @(negedge clk);
        rd(8'h1A, v); chk("R8 fetch aborted by hpd", v, 8'h00);
        fw_running = 1'b0;
        fetch(8'h05, 3);
        rd(8'h1A, v); chk("R8 no valid without fw", v, 8'h00);
        fw_running = 1'b1;
    endtask

    task automatic t_readonly;
        logic [7:0] v;
        fetch(8'h06, 3);
        hw(8'h19, 8'hAA, 8'hFF);
        hw(8'h1A, 8'h00, 8'hFF);
        hw(8'h1C, 8'h55, 8'hFF);
        rd(8'h19, v); chk("R9 mirror ro", v, 8'h06);
        rd(8'h1A, v); chk("R9 valid ro", v, 8'h01);
        rd(8'h1C, v); chk("R9 data ro", v, tbyte(24));
        rd(8'h7E, v); chk("R9 unmapped", v, 8'h00);
    endtask

    task automatic t_side_load;
        logic [7:0] v;
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 8'd8; tbl_wdata = 8'h5A;
        @(negedge clk);
        tbl_we = 1'b0;
        fetch(8'h02, 3);
        rd(8'h1C, v); chk("R10 side byte", v, 8'h5A);
        rd(8'h1D, v); chk("R10 neighbour", v, tbyte(9));
    endtask

    task automatic t_done_flag;
        logic [7:0] v;
        hw(8'h20, 8'h01, 8'h01);
        rd(8'h20, v); chk("R11 done set", v, 8'h01);
        rd(8'h1A, v); chk("R11 valid untouched", v, 8'h01);
        hw(8'h20, 8'h00, 8'h01);
        rd(8'h20, v); chk("R11 done clear", v, 8'h00);
        rd(8'h1A, v); chk("R11 valid still", v, 8'h01);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 8'(a); tbl_wdata = tbyte(a);
        end
        @(negedge clk);
        tbl_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_mask();
        t_fetch_timing();
        t_rewrite();
        t_lat_zero();
        t_ptr_edges();
        t_status_loss();
        t_readonly();
        t_side_load();
        t_done_flag();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule